// File: doc/BRIEF.md
# Filtered Quadrature Front End

This block sits between the A, B and index pins of an incremental encoder and an up/down position counter. Each of the three pins is first brought into the clock domain, then digitally filtered. The filter samples only on a strobe produced by an 8-bit programmable prescaler, so all three filtered signals change on the same sample and stay phase-aligned. The filtered A/B pair is decoded into a one-cycle count pulse with a direction bit, at one, two or four counts per encoder cycle. In the direct mode the filter and decoder are bypassed: A is taken as a count clock and B as the direction level.

The block flags noise with a sticky error bit. The bit is set when both filtered channels change on the same sample, which a real encoder never does, and it is cleared only by an explicit command. The index pin produces a one-cycle event. In synchronous mode the event is aligned to the filter samples and follows a programmable active level. Otherwise the event is taken from the falling edge of the synchronized pin.

The block only produces pulses and events. The position counter and any host register access sit outside it.

Top module: `qdec_front`

## Requirements
- R1: While reset is asserted, and after it is released with quiet inputs, `cnt_pulse`, `cnt_up`, `err_flag` and `idx_event` are all 0. The prescale value resets to 0, so a sample is taken every clock.
- R2: With prescale value n (0 to 255), the filter samples once every n+1 clocks. A new value on `psc_value` takes effect only in a cycle where `psc_load` is 1.
- R3: A filtered channel takes a new level only after two consecutive samples have seen that level. A pulse that can be caught by at most one sample is discarded.
- R4: `dec_mode` 2'b11 selects four counts per cycle. Every sample where exactly one of filtered A/B changed gives one pulse, with `cnt_up` = new A XOR previous B, so A leading B counts up. `cnt_up` changes only together with a pulse.
- R5: `dec_mode` 2'b10 selects two counts per cycle. Only changes of filtered A (with B unchanged) count, and the direction rule of R4 applies.
- R6: `dec_mode` 2'b01 selects one count per cycle. Only a change of filtered A while filtered B is 0 counts: an A rise counts up and an A fall counts down.
- R7: `dec_mode` 2'b00 is the direct mode. Each rising edge of the synchronized A pin gives one pulse with `cnt_up` equal to the synchronized B pin. The prescaler setting has no effect on this path.
- R8: In modes 01/10/11, a sample on which both filtered A and B change sets `err_flag` and gives no pulse. The flag stays set until `err_clear`, and a set in the same cycle as a clear wins. In mode 00 the flag is never set.
- R9: When `idx_enable` is 1 and the mode is not 00, `idx_event` pulses on the sample where the filtered index first reaches the level given by `idx_polarity` (1 = active high, 0 = active low). A pulse rejected by the filter gives no event.
- R10: When `idx_enable` is 0 or the mode is 00, `idx_event` pulses once for every falling edge of the synchronized index pin, with no filtering.
- R11: In modes 01/10/11, a counted edge on A gives its pulse no later than 2(n+1)+4 clocks after the pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_load | input | 1 | Take `psc_value` as the new prescale value |
| psc_value | input | PSC_W | Prescale value n; samples every n+1 clocks |
| dec_mode | input | 2 | 00 direct, 01 one count, 10 two counts, 11 four counts per cycle |
| idx_enable | input | 1 | 1 selects the sample-aligned index mode |
| idx_polarity | input | 1 | Active index level in sample-aligned mode |
| err_clear | input | 1 | Clear the sticky noise flag |
| a_in | input | 1 | Encoder channel A (asynchronous) |
| b_in | input | 1 | Encoder channel B (asynchronous) |
| idx_in | input | 1 | Encoder index pin (asynchronous) |
| cnt_pulse | output | 1 | One-cycle count pulse |
| cnt_up | output | 1 | Direction of the latest pulse, 1 = up |
| err_flag | output | 1 | Sticky noise flag |
| idx_event | output | 1 | One-cycle index event |

## Verification
The noise detector can set the error flag in the same cycle that the host clears it. The bench provokes this by holding `err_clear` high without a break while it moves A and B together in four-count mode. The correct behaviour is for the flag to be seen high for exactly the cycle after that sample and to read low again afterwards. A design where the clear wins would never show the flag at all. Index events and count pulses can also come from the same filter sample; the bench counts the index events separately from the queue of expected pulses, so neither can hide the other.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'b00,
        MODE_X1     = 2'b01,
        MODE_X2     = 2'b10,
        MODE_X4     = 2'b11
    } dec_mode_e;

    localparam int NUM_CH = 3;
    localparam int CH_A   = 0;
    localparam int CH_B   = 1;
    localparam int CH_IDX = 2;

endpackage

// File: rtl/qdec_prescale.sv
module qdec_prescale #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         tick,
    output logic         strobe,
    output logic [W-1:0] reload
);

    typedef struct packed {
        logic [W-1:0] rld;
        logic [W-1:0] cnt;
        logic         tick;
        logic         strobe;
    } psc_state_t;

    psc_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.tick   = 1'b0;
        st_d.strobe = st_q.tick;
        if (load) begin
            st_d.rld = value;
            st_d.cnt = value;
        end else if (st_q.cnt == '0) begin
            st_d.cnt  = st_q.rld;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick   = st_q.tick;
    assign strobe = st_q.strobe;
    assign reload = st_q.rld;

endmodule

// File: rtl/qdec_chan_filter.sv
module qdec_chan_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic tick,
    output logic syn,
    output logic flt
);

    localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [SW-1:0] sync;
        logic          smp;
        logic          flt;
    } flt_state_t;

    flt_state_t fs_d, fs_q;
    logic       syn_lvl;

    assign syn_lvl = fs_q.sync[SW-1];

    always_comb begin
        fs_d      = fs_q;
        fs_d.sync = {fs_q.sync[SW-2:0], raw};
        if (tick) begin
            fs_d.smp = syn_lvl;
            if (syn_lvl == fs_q.smp) fs_d.flt = syn_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign syn = syn_lvl;
    assign flt = fs_q.flt;

endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
    import qdec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dec_mode_e mode,
    input  logic      idx_en,
    input  logic      idx_pol,
    input  logic      err_clr,
    input  logic      stb,
    input  logic      flt_a,
    input  logic      flt_b,
    input  logic      flt_i,
    input  logic      syn_a,
    input  logic      syn_b,
    input  logic      syn_i,
    output logic      pulse,
    output logic      up,
    output logic      err,
    output logic      evt
);

    typedef struct packed {
        logic prv_a;
        logic prv_b;
        logic prv_i;
        logic syn_a_prv;
        logic syn_i_prv;
        logic pulse;
        logic up;
        logic err;
        logic evt;
    } dec_state_t;

    dec_state_t ds_d, ds_q;
    logic       ch_a, ch_b, quad_dir, sync_idx;

    always_comb begin
        ds_d           = ds_q;
        ds_d.pulse     = 1'b0;
        ds_d.evt       = 1'b0;
        ds_d.syn_a_prv = syn_a;
        ds_d.syn_i_prv = syn_i;
        ch_a           = flt_a ^ ds_q.prv_a;
        ch_b           = flt_b ^ ds_q.prv_b;
        quad_dir       = flt_a ^ ds_q.prv_b;
        sync_idx       = idx_en && (mode != MODE_DIRECT);

        if (err_clr) ds_d.err = 1'b0;

        if (mode == MODE_DIRECT) begin
            if (syn_a && !ds_q.syn_a_prv) begin
                ds_d.pulse = 1'b1;
                ds_d.up    = syn_b;
            end
        end else if (stb) begin
            if (ch_a && ch_b) begin
                ds_d.err = 1'b1;
            end else begin
                case (mode)
                    MODE_X4: if (ch_a || ch_b) begin
                        ds_d.pulse = 1'b1;
                        ds_d.up    = quad_dir;
                    end
                    MODE_X2: if (ch_a) begin
                        ds_d.pulse = 1'b1;
                        ds_d.up    = quad_dir;
                    end
                    MODE_X1: if (ch_a && !flt_b) begin
                        ds_d.pulse = 1'b1;
                        ds_d.up    = flt_a;
                    end
                    default: ;
                endcase
            end
        end

        if (stb) begin
            ds_d.prv_a = flt_a;
            ds_d.prv_b = flt_b;
            ds_d.prv_i = flt_i;
        end

        if (sync_idx) begin
            if (stb && (flt_i == idx_pol) && (ds_q.prv_i != idx_pol)) ds_d.evt = 1'b1;
        end else if (!syn_i && ds_q.syn_i_prv) begin
            ds_d.evt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ds_q <= '0;
        else        ds_q <= ds_d;
    end

    assign pulse = ds_q.pulse;
    assign up    = ds_q.up;
    assign err   = ds_q.err;
    assign evt   = ds_q.evt;

endmodule

// File: rtl/qdec_front.sv
module qdec_front
    import qdec_pkg::*;
#(
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psc_load,
    input  logic [PSC_W-1:0] psc_value,
    input  logic [1:0]       dec_mode,
    input  logic             idx_enable,
    input  logic             idx_polarity,
    input  logic             err_clear,
    input  logic             a_in,
    input  logic             b_in,
    input  logic             idx_in,
    output logic             cnt_pulse,
    output logic             cnt_up,
    output logic             err_flag,
    output logic             idx_event
);

    logic              tick;
    logic              strobe;
    logic [PSC_W-1:0]  psc_reload;
    logic [NUM_CH-1:0] pin_raw;
    logic [NUM_CH-1:0] pin_syn;
    logic [NUM_CH-1:0] pin_flt;

    qdec_prescale #(.W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (psc_load),
        .value  (psc_value),
        .tick   (tick),
        .strobe (strobe),
        .reload (psc_reload)
    );

    assign pin_raw[CH_A]   = a_in;
    assign pin_raw[CH_B]   = b_in;
    assign pin_raw[CH_IDX] = idx_in;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        qdec_chan_filter #(.SYNC_STAGES(SYNC_STAGES)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (pin_raw[g]),
            .tick  (tick),
            .syn   (pin_syn[g]),
            .flt   (pin_flt[g])
        );
    end

    qdec_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (dec_mode_e'(dec_mode)),
        .idx_en  (idx_enable),
        .idx_pol (idx_polarity),
        .err_clr (err_clear),
        .stb     (strobe),
        .flt_a   (pin_flt[CH_A]),
        .flt_b   (pin_flt[CH_B]),
        .flt_i   (pin_flt[CH_IDX]),
        .syn_a   (pin_syn[CH_A]),
        .syn_b   (pin_syn[CH_B]),
        .syn_i   (pin_syn[CH_IDX]),
        .pulse   (cnt_pulse),
        .up      (cnt_up),
        .err     (err_flag),
        .evt     (idx_event)
    );

endmodule

// File: rtl/qdec_front_chk.sv
module qdec_front_chk #(
    parameter int PSC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       dec_mode,
    input logic             idx_enable,
    input logic             err_clear,
    input logic             psc_load,
    input logic             cnt_pulse,
    input logic             cnt_up,
    input logic             err_flag,
    input logic             idx_event,
    input logic             tick,
    input logic             strobe,
    input logic [PSC_W-1:0] psc_reload
);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clear) |=> err_flag);

    assert_err_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_mode == 2'b00) |=> !$rose(err_flag));

    assert_err_no_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> !cnt_pulse);

    assert_dir_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_pulse |-> $stable(cnt_up));

    assert_psc_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (psc_reload != '0) && !psc_load) |=> !tick);

    assert_quad_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pulse && $past(dec_mode) != 2'b00) |-> $past(strobe));

    assert_idx_on_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_event && $past(idx_enable) && $past(dec_mode) != 2'b00) |-> $past(strobe));

endmodule

bind qdec_front qdec_front_chk #(.PSC_W(PSC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_mode   (dec_mode),
    .idx_enable (idx_enable),
    .err_clear  (err_clear),
    .psc_load   (psc_load),
    .cnt_pulse  (cnt_pulse),
    .cnt_up     (cnt_up),
    .err_flag   (err_flag),
    .idx_event  (idx_event),
    .tick       (tick),
    .strobe     (strobe),
    .psc_reload (psc_reload)
);

// File: tb/sim_qdec_front.sv
module sim_qdec_front;

    localparam int CLK_PERIOD = 10;
    localparam int PSC_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             psc_load = 1'b0;
    logic [PSC_W-1:0] psc_value = '0;
    logic [1:0]       dec_mode = 2'b11;
    logic             idx_enable = 1'b1;
    logic             idx_polarity = 1'b1;
    logic             err_clear = 1'b0;
    logic             a_in = 1'b0;
    logic             b_in = 1'b0;
    logic             idx_in = 1'b0;
    logic             cnt_pulse, cnt_up, err_flag, idx_event;

    qdec_front #(.PSC_W(PSC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .psc_load(psc_load), .psc_value(psc_value),
        .dec_mode(dec_mode), .idx_enable(idx_enable), .idx_polarity(idx_polarity),
        .err_clear(err_clear), .a_in(a_in), .b_in(b_in), .idx_in(idx_in),
        .cnt_pulse(cnt_pulse), .cnt_up(cnt_up), .err_flag(err_flag), .idx_event(idx_event)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    int    idx_seen = 0;
    bit    err_seen = 1'b0;
    bit    finished = 1'b0;
    string sb_req = "R1";
    logic  exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops one expected direction per observed count pulse.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cnt_pulse) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, {sb_req, " unexpected pulse"}, 1, 0);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    check(cnt_up == e, {sb_req, " direction"}, int'(cnt_up), int'(e));
                end
            end
            if (idx_event) idx_seen++;
            if (err_flag)  err_seen = 1'b1;
        end
    end

    // Driver: moves the pins and pushes what the requirements predict.
    task automatic move(input logic na, input logic nb, input int hold);
        logic cha, chb;
        cha = na ^ a_in;
        chb = nb ^ b_in;
        if (dec_mode == 2'b00) begin
            if (cha && na) exp_q.push_back(nb);
        end else if (!(cha && chb)) begin
            case (dec_mode)
                2'b11: if (cha || chb) exp_q.push_back(na ^ b_in);
                2'b10: if (cha) exp_q.push_back(na ^ b_in);
                2'b01: if (cha && !b_in) exp_q.push_back(na);
                default: ;
            endcase
        end
        @(negedge clk);
        a_in = na;
        b_in = nb;
        repeat (hold) @(negedge clk);
    endtask

    task automatic fwd(input int steps, input int hold);
        for (int i = 0; i < steps; i++) move(~b_in, a_in, hold);
    endtask

    task automatic rev(input int steps, input int hold);
        for (int i = 0; i < steps; i++) move(b_in, ~a_in, hold);
    endtask

    task automatic drain(input int cyc, input string req);
        repeat (cyc) @(negedge clk);
        check(exp_q.size() == 0, {req, " pending pulses"}, exp_q.size(), 0);
    endtask

    task automatic load_psc(input int v);
        @(negedge clk);
        psc_value = PSC_W'(v);
        psc_load  = 1'b1;
        @(negedge clk);
        psc_load  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (4) @(negedge clk);
        check(!cnt_pulse && !err_flag && !idx_event && !cnt_up, "R1 in reset",
              {cnt_pulse, cnt_up, err_flag, idx_event}, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(!cnt_pulse && !err_flag && !idx_event && !cnt_up, "R1 after reset",
              {cnt_pulse, cnt_up, err_flag, idx_event}, 0);

        // Four counts per cycle, n = 1
        load_psc(1);
        repeat (20) @(negedge clk);
        sb_req = "R4";
        fwd(8, 8);  drain(40, "R4 up");
        rev(8, 8);  drain(40, "R4 down");

        sb_req = "R5"; dec_mode = 2'b10;
        fwd(8, 8);  rev(4, 8); drain(40, "R5");

        sb_req = "R6"; dec_mode = 2'b01;
        fwd(8, 8);  rev(8, 8); drain(40, "R6");

        // Filter glitch rejection, n = 3
        sb_req = "R3"; dec_mode = 2'b11;
        load_psc(3);
        repeat (20) @(negedge clk);
        a_in = 1'b1;
        @(negedge clk);
        a_in = 1'b0;
        drain(60, "R3 glitch");
        move(1'b1, 1'b0, 16); move(1'b0, 1'b0, 16);
        drain(40, "R3 valid");

        // Latency bound
        sb_req = "R11";
        exp_q.push_back(1'b1);
        a_in = 1'b1;
        lat = 0;
        while (lat < 100) begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (cnt_pulse) break;
        end
        check(lat <= 2*4+4 && lat >= 4, "R11 latency", lat, 2*4+4);
        move(1'b0, 1'b0, 16);
        drain(40, "R11");

        // Prescale value without load has no effect; with load it widens the filter
        sb_req = "R2";
        psc_value = 8'd255;
        move(1'b1, 1'b0, 100); move(1'b0, 1'b0, 100);
        drain(60, "R2 no load");
        load_psc(255);
        repeat (600) @(negedge clk);
        a_in = 1'b1;
        repeat (100) @(negedge clk);
        a_in = 1'b0;
        drain(1200, "R2 after load");
        load_psc(1);
        repeat (20) @(negedge clk);

        // Noise error
        sb_req = "R8";
        @(negedge clk);
        a_in = 1'b1; b_in = 1'b1;
        repeat (20) @(negedge clk);
        check(err_flag == 1'b1, "R8 set", err_flag, 1);
        drain(10, "R8 no count");
        fwd(4, 8); drain(30, "R8 counts");
        check(err_flag == 1'b1, "R8 sticky", err_flag, 1);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        @(negedge clk);
        check(err_flag == 1'b0, "R8 clear", err_flag, 0);
        // set and clear in the same cycle
        err_clear = 1'b1;
        repeat (3) @(negedge clk);
        err_seen = 1'b0;
        a_in = 1'b0; b_in = 1'b0;
        repeat (30) @(negedge clk);
        err_clear = 1'b0;
        @(negedge clk);
        check(err_seen == 1'b1, "R8 set wins", err_seen, 1);
        check(err_flag == 1'b0, "R8 cleared after", err_flag, 0);
        drain(5, "R8 no count on double");

        // Direct mode, slow prescaler must not matter
        sb_req = "R7"; dec_mode = 2'b00;
        load_psc(255);
        move(1'b0, 1'b1, 4);
        for (int i = 0; i < 4; i++) begin move(1'b1, 1'b1, 3); move(1'b0, 1'b1, 3); end
        move(1'b0, 1'b0, 4);
        for (int i = 0; i < 3; i++) begin move(1'b1, 1'b0, 3); move(1'b0, 1'b0, 3); end
        drain(10, "R7");
        repeat (1100) @(negedge clk);
        check(err_flag == 1'b0, "R8 direct no error", err_flag, 0);
        load_psc(1);
        repeat (40) @(negedge clk);
        dec_mode = 2'b11;
        repeat (10) @(negedge clk);

        // Sample-aligned index
        idx_seen = 0;
        idx_in = 1'b1;
        @(negedge clk);
        idx_in = 1'b0;
        repeat (20) @(negedge clk);
        check(idx_seen == 0, "R9 glitch rejected", idx_seen, 0);
        idx_in = 1'b1;
        repeat (10) @(negedge clk);
        idx_in = 1'b0;
        repeat (20) @(negedge clk);
        check(idx_seen == 1, "R9 active high", idx_seen, 1);
        idx_polarity = 1'b0;
        repeat (10) @(negedge clk);
        idx_in = 1'b1;
        repeat (20) @(negedge clk);
        check(idx_seen == 1, "R9 leaving active", idx_seen, 1);
        idx_in = 1'b0;
        repeat (10) @(negedge clk);
        idx_in = 1'b1;
        repeat (20) @(negedge clk);
        check(idx_seen == 2, "R9 active low", idx_seen, 2);

        // Unfiltered index
        idx_enable = 1'b0;
        repeat (5) @(negedge clk);
        idx_in = 1'b0;
        @(negedge clk);
        idx_in = 1'b1;
        repeat (10) @(negedge clk);
        check(idx_seen == 3, "R10 enable off", idx_seen, 3);
        idx_enable = 1'b1; dec_mode = 2'b00;
        repeat (5) @(negedge clk);
        idx_in = 1'b0;
        repeat (2) @(negedge clk);
        idx_in = 1'b1;
        repeat (10) @(negedge clk);
        check(idx_seen == 4, "R10 direct mode", idx_seen, 4);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule